// File: doc/BRIEF.md
# Serial In-System Programming Slave

This block lets an external programmer fill two small on-chip arrays over a three-wire serial link: a clock, a data input and a data output. It acts only while the device reset pin is held low. The serial clock and data are resynchronised into the system clock domain. Each clock phase must pass a minimum-width filter before it counts as an edge. Every instruction is a fixed 32-bit frame. The first frame the block honours must be the enable frame; all others are dropped until that frame has succeeded.

Once the block is enabled, the programmer can read and write a word-organised program array (with a byte select) and a byte-organised data array. It can also erase both arrays at once and poll a busy flag. Writes and erases are self-timed: they take a fixed number of system cycles and then commit. While they run, further writes are refused. The program array behaves like flash: a write can only clear bits. The data array erases the target byte itself before it writes.

Top module: `isp_slave`

## Requirements
- R1: After system reset `miso` is 0 and `sck_glitch` has not pulsed. The block works only while `tgt_rst_n` is low. Raising `tgt_rst_n` drops any partial frame, cancels any pending write or erase and clears the enabled state, so the next frames are locked out again.
- R2: Until an enable frame succeeds, every other frame is ignored. A write does not change the arrays, and a read returns the echo described in R4 instead of array data.
- R3: An enable frame has first byte 0xAC and a third byte equal to its second byte. A frame with 0xAC first and mismatched second and third bytes leaves the block locked.
- R4: A frame is four bytes, most significant bit first: opcode, address high, address low, data. During the fourth byte `miso` shifts out the response. For every frame other than an enabled read or poll, that response is the second byte.
- R5: `mosi` is taken at the rising edge of `sck`. `miso` changes only after a falling edge of `sck`, so it is stable by the next rising edge.
- R6: An `sck` phase lasting no more than T system clocks is ignored and raises `sck_glitch` for one cycle. T is 2 when FAST_CLK=0 and 3 when FAST_CLK=1. A phase of T+1 clocks is accepted.
- R7: A write or erase holds the block busy for WR_CYCLES system cycles and then commits. The poll frame (opcode 0xF0) returns the busy flag in bit 0 of its response, with the other bits 0.
- R8: A write or erase frame that completes while the block is busy is ignored.
- R9: Program array: opcode 0x40 writes the low byte and 0x48 the high byte; 0x20 reads the low byte and 0x28 the high byte. Opcode bit 3 selects the high byte. The word address is {byte2, byte3}. A write ANDs the new data into the stored byte.
- R10: Data array: opcode 0xC0 writes and 0xA0 reads the byte at address {byte2, byte3}. A write stores the data exactly, whatever the byte held before.
- R11: After system reset, and after an enabled frame 0xAC 0x80 x x has committed, every byte of both arrays reads 0xFF.
- R12: Address bits above log2 of the array size are ignored, so addresses wrap onto the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| tgt_rst_n | input | 1 | Device reset pin; programming is active while low |
| sck | input | 1 | Serial clock from the programmer |
| mosi | input | 1 | Serial data from the programmer |
| miso | output | 1 | Serial data to the programmer |
| sck_glitch | output | 1 | One-cycle pulse when an `sck` phase was too short |

## Verification
The bench builds the block with 32 program words, 16 data bytes, WR_CYCLES=1500 and FAST_CLK=0. With these values, one 640-cycle frame fits inside a busy window, so a poll made straight after a write reads busy. A second write sent inside the same window meets the refusal path. The small arrays put address wrap within easy reach through oversized high bytes. The threshold of 2 lets the bench probe both sides of the pulse filter: a 2-clock pulse is rejected, and a frame clocked with 3-clock phases is accepted.

// File: rtl/isp_pkg.sv
package isp_pkg;
  typedef enum logic [1:0] {
    WOP_NONE  = 2'd0,
    WOP_PGM   = 2'd1,
    WOP_DAT   = 2'd2,
    WOP_ERASE = 2'd3
  } wr_op_e;

  localparam logic [7:0] OPC_ENABLE  = 8'hAC;
  localparam logic [7:0] ERASE_KEY   = 8'h80;
  localparam logic [7:0] OPC_PGM_RD  = 8'h20;
  localparam logic [7:0] OPC_PGM_WR  = 8'h40;
  localparam logic [7:0] OPC_DAT_RD  = 8'hA0;
  localparam logic [7:0] OPC_DAT_WR  = 8'hC0;
  localparam logic [7:0] OPC_POLL    = 8'hF0;
  localparam logic [7:0] HI_SEL_MASK = 8'h08;
endpackage

// File: rtl/isp_sck_filter.sv
module isp_sck_filter #(
  parameter bit FAST_CLK = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgt_rst_n,
  input  logic sck,
  input  logic mosi,
  output logic active,
  output logic rise,
  output logic fall,
  output logic glitch,
  output logic sdi_bit
);
  localparam int unsigned MIN_PH = FAST_CLK ? 3 : 2;
  localparam int unsigned CW     = $clog2(MIN_PH + 1);

  logic r1, r2, s1, s2, s3, m1, m2;
  logic lvl, lvl_d, smp, smp_d;
  logic [CW-1:0] stab, stab_d;
  logic rise_d, fall_d, glitch_d;

  always_comb begin
    lvl_d    = lvl;
    stab_d   = stab;
    smp_d    = smp;
    rise_d   = 1'b0;
    fall_d   = 1'b0;
    glitch_d = 1'b0;
    if (s2 && !s3) smp_d = m2;
    if (s2 == lvl) begin
      stab_d   = '0;
      glitch_d = (stab != '0);
    end else if (stab == CW'(MIN_PH)) begin
      lvl_d  = s2;
      stab_d = '0;
      rise_d = s2;
      fall_d = ~s2;
    end else begin
      stab_d = stab + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r1 <= 1'b1; r2 <= 1'b1;
      s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
      m1 <= 1'b0; m2 <= 1'b0;
      lvl <= 1'b0; stab <= '0; smp <= 1'b0;
      rise <= 1'b0; fall <= 1'b0; glitch <= 1'b0;
    end else begin
      r1 <= tgt_rst_n; r2 <= r1;
      s1 <= sck;  s2 <= s1; s3 <= s2;
      m1 <= mosi; m2 <= m1;
      lvl    <= lvl_d;
      stab   <= stab_d;
      smp    <= smp_d;
      rise   <= rise_d;
      fall   <= fall_d;
      glitch <= glitch_d;
    end
  end

  assign active  = ~r2;
  assign sdi_bit = smp;
endmodule

// File: rtl/isp_frame.sv
module isp_frame (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        active,
  input  logic        rise,
  input  logic        fall,
  input  logic        sdi,
  input  logic [7:0]  resp,
  output logic        hdr_vld,
  output logic [23:0] hdr,
  output logic        done,
  output logic [7:0]  last,
  output logic        sdo
);
  logic [22:0] sh, sh_d;
  logic [4:0]  cnt, cnt_d;
  logic [23:0] hdr_d;
  logic [7:0]  last_d, tx, tx_d;
  logic        hdr_vld_d, done_d, sdo_d;

  always_comb begin
    sh_d      = sh;
    cnt_d     = cnt;
    hdr_d     = hdr;
    last_d    = last;
    tx_d      = tx;
    sdo_d     = sdo;
    hdr_vld_d = 1'b0;
    done_d    = 1'b0;
    if (!active) begin
      cnt_d = '0;
      sdo_d = 1'b0;
    end else begin
      if (rise) begin
        sh_d  = {sh[21:0], sdi};
        cnt_d = cnt + 1'b1;
        if (cnt == 5'd23) begin
          hdr_d     = {sh, sdi};
          hdr_vld_d = 1'b1;
        end
        if (cnt == 5'd31) begin
          last_d = {sh[6:0], sdi};
          done_d = 1'b1;
        end
      end
      if (hdr_vld) tx_d = resp;
      if (fall) sdo_d = (cnt[4:3] == 2'b11) ? tx[~cnt[2:0]] : 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; cnt <= '0; hdr <= '0; last <= '0; tx <= '0;
      sdo <= 1'b0; hdr_vld <= 1'b0; done <= 1'b0;
    end else begin
      sh      <= sh_d;
      cnt     <= cnt_d;
      hdr     <= hdr_d;
      last    <= last_d;
      tx      <= tx_d;
      sdo     <= sdo_d;
      hdr_vld <= hdr_vld_d;
      done    <= done_d;
    end
  end
endmodule

// File: rtl/isp_core.sv
module isp_core
  import isp_pkg::*;
#(
  parameter int unsigned PGM_WORDS = 64,
  parameter int unsigned DAT_BYTES = 32,
  parameter int unsigned WR_CYCLES = 2000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        active,
  input  logic [23:0] hdr,
  input  logic        done,
  input  logic [7:0]  last,
  output logic [7:0]  resp,
  output logic        busy,
  output logic        en
);
  localparam int unsigned PAW = $clog2(PGM_WORDS);
  localparam int unsigned DAW = $clog2(DAT_BYTES);
  localparam int unsigned BCW = $clog2(WR_CYCLES + 1);

  logic [7:0] pgm_lo [PGM_WORDS];
  logic [7:0] pgm_hi [PGM_WORDS];
  logic [7:0] dat    [DAT_BYTES];

  logic [7:0]  b0, b1, b2;
  logic [15:0] fadr;
  logic [PAW-1:0] pa, pa_q, pa_d;
  logic [DAW-1:0] da, da_q, da_d;
  logic        hi_q, hi_d;
  logic [7:0]  pdat, pdat_d;
  wr_op_e      op_q, op_d;
  logic [BCW-1:0] bcnt, bcnt_d;
  logic        busy_d, en_d, commit;
  logic        is_prd, is_drd, is_poll, is_pwr, is_dwr, is_erase, is_enable;

  assign b0   = hdr[23:16];
  assign b1   = hdr[15:8];
  assign b2   = hdr[7:0];
  assign fadr = {b1, b2};
  assign pa   = fadr[PAW-1:0];
  assign da   = fadr[DAW-1:0];

  assign is_prd    = (b0 & ~HI_SEL_MASK) == OPC_PGM_RD;
  assign is_pwr    = (b0 & ~HI_SEL_MASK) == OPC_PGM_WR;
  assign is_drd    = b0 == OPC_DAT_RD;
  assign is_dwr    = b0 == OPC_DAT_WR;
  assign is_poll   = b0 == OPC_POLL;
  assign is_erase  = (b0 == OPC_ENABLE) && (b1 == ERASE_KEY);
  assign is_enable = (b0 == OPC_ENABLE) && (b2 == b1);

  always_comb begin
    resp = b1;
    if (en) begin
      if (is_prd)       resp = (b0 & HI_SEL_MASK) != 8'h00 ? pgm_hi[pa] : pgm_lo[pa];
      else if (is_drd)  resp = dat[da];
      else if (is_poll) resp = {7'b0, busy};
    end
  end

  always_comb begin
    en_d   = en;
    busy_d = busy;
    bcnt_d = bcnt;
    op_d   = op_q;
    pa_d   = pa_q;
    da_d   = da_q;
    hi_d   = hi_q;
    pdat_d = pdat;
    commit = 1'b0;
    if (busy) begin
      if (bcnt == BCW'(WR_CYCLES - 1)) begin
        commit = 1'b1;
        busy_d = 1'b0;
      end else begin
        bcnt_d = bcnt + 1'b1;
      end
    end
    if (done) begin
      if (!en) begin
        if (is_enable) en_d = 1'b1;
      end else if (!busy && (is_erase || is_pwr || is_dwr)) begin
        busy_d = 1'b1;
        bcnt_d = '0;
        pa_d   = pa;
        da_d   = da;
        hi_d   = (b0 & HI_SEL_MASK) != 8'h00;
        pdat_d = last;
        op_d   = is_erase ? WOP_ERASE : (is_pwr ? WOP_PGM : WOP_DAT);
      end
    end
    if (!active) begin
      en_d   = 1'b0;
      busy_d = 1'b0;
      commit = 1'b0;
      op_d   = WOP_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; busy <= 1'b0; bcnt <= '0; op_q <= WOP_NONE;
      pa_q <= '0; da_q <= '0; hi_q <= 1'b0; pdat <= '0;
    end else begin
      en   <= en_d;
      busy <= busy_d;
      bcnt <= bcnt_d;
      op_q <= op_d;
      pa_q <= pa_d;
      da_q <= da_d;
      hi_q <= hi_d;
      pdat <= pdat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(PGM_WORDS); i++) begin
        pgm_lo[i] <= 8'hFF;
        pgm_hi[i] <= 8'hFF;
      end
      for (int j = 0; j < int'(DAT_BYTES); j++) dat[j] <= 8'hFF;
    end else if (commit) begin
      case (op_q)
        WOP_ERASE: begin
          for (int i = 0; i < int'(PGM_WORDS); i++) begin
            pgm_lo[i] <= 8'hFF;
            pgm_hi[i] <= 8'hFF;
          end
          for (int j = 0; j < int'(DAT_BYTES); j++) dat[j] <= 8'hFF;
        end
        WOP_PGM: begin
          if (hi_q) pgm_hi[pa_q] <= pgm_hi[pa_q] & pdat;
          else      pgm_lo[pa_q] <= pgm_lo[pa_q] & pdat;
        end
        WOP_DAT: dat[da_q] <= pdat;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/isp_slave.sv
module isp_slave #(
  parameter int unsigned PGM_WORDS = 64,
  parameter int unsigned DAT_BYTES = 32,
  parameter int unsigned WR_CYCLES = 2000,
  parameter bit          FAST_CLK  = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgt_rst_n,
  input  logic sck,
  input  logic mosi,
  output logic miso,
  output logic sck_glitch
);
  logic        active, sck_rise, sck_fall, sdi_bit;
  logic        hdr_vld, done, busy, en;
  logic [23:0] hdr;
  logic [7:0]  last, resp;

  isp_sck_filter #(.FAST_CLK(FAST_CLK)) u_filt (
    .clk(clk), .rst_n(rst_n), .tgt_rst_n(tgt_rst_n), .sck(sck), .mosi(mosi),
    .active(active), .rise(sck_rise), .fall(sck_fall), .glitch(sck_glitch),
    .sdi_bit(sdi_bit)
  );

  isp_frame u_frame (
    .clk(clk), .rst_n(rst_n), .active(active), .rise(sck_rise), .fall(sck_fall),
    .sdi(sdi_bit), .resp(resp), .hdr_vld(hdr_vld), .hdr(hdr), .done(done),
    .last(last), .sdo(miso)
  );

  isp_core #(
    .PGM_WORDS(PGM_WORDS), .DAT_BYTES(DAT_BYTES), .WR_CYCLES(WR_CYCLES)
  ) u_core (
    .clk(clk), .rst_n(rst_n), .active(active), .hdr(hdr), .done(done),
    .last(last), .resp(resp), .busy(busy), .en(en)
  );
endmodule

// File: rtl/isp_slave_chk.sv
module isp_slave_chk #(
  parameter int unsigned WR_CYCLES = 2000
) (
  input logic clk,
  input logic rst_n,
  input logic active,
  input logic rise,
  input logic fall,
  input logic glitch,
  input logic busy,
  input logic en,
  input logic sdo
);
  int unsigned busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= 0;
    else if (busy) busy_len <= busy_len + 1;
    else           busy_len <= 0;
  end

  assert_idle_when_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!busy && !en && !sdo));

  assert_busy_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(en));

  assert_sdo_moves_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> ($past(fall) || !$past(active)));

  assert_edges_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise, fall, glitch}));

  assert_busy_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && active && $past(active)) |-> (busy_len == WR_CYCLES));
endmodule

bind isp_slave isp_slave_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .active(active), .rise(sck_rise), .fall(sck_fall),
  .glitch(sck_glitch), .busy(busy), .en(en), .sdo(miso)
);

// File: tb/sim_isp_slave.sv
module sim_isp_slave;
  localparam int WRC = 1500;

  logic clk, rst_n, tgt_rst_n, sck, mosi, miso, sck_glitch;
  int   n_chk, n_err, gl_cnt;
  logic [7:0] exp_q[$];
  logic [7:0] got_q[$];
  string      tag_q[$];

  isp_slave #(.PGM_WORDS(32), .DAT_BYTES(16), .WR_CYCLES(WRC), .FAST_CLK(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .tgt_rst_n(tgt_rst_n), .sck(sck), .mosi(mosi),
    .miso(miso), .sck_glitch(sck_glitch)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) if (rst_n && sck_glitch) gl_cnt++;

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, input int h, output logic got);
    mosi = b;
    wait_clk(h);
    got = miso;
    sck = 1'b1;
    wait_clk(h);
    sck = 1'b0;
  endtask

  task automatic frame(input logic [7:0] b0, b1, b2, b3, input int h, output logic [7:0] r);
    logic [31:0] w;
    logic g;
    w = {b0, b1, b2, b3};
    r = 8'h00;
    for (int i = 31; i >= 0; i--) begin
      send_bit(w[i], h, g);
      if (i < 8) r[i] = g;
    end
    wait_clk(4);
  endtask

  task automatic xfer(input logic [7:0] b0, b1, b2, b3, input logic [7:0] exp, input string tag);
    logic [7:0] r;
    frame(b0, b1, b2, b3, 10, r);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    got_q.push_back(r);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      while (got_q.size() != 0) begin
        logic [7:0] g, e;
        string t;
        g = got_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, g, e);
      end
    end
  end

  task automatic finish_run;
    wait_clk(3);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin : watchdog
    wait_clk(200000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin : driver
    logic [7:0] r;
    logic g;
    n_chk = 0; n_err = 0; gl_cnt = 0;
    rst_n = 1'b0; tgt_rst_n = 1'b1; sck = 1'b0; mosi = 1'b0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    check("R1 reset miso", {7'b0, miso}, 8'h00);
    check("R1 reset glitch count", 8'(gl_cnt), 8'h00);
    tgt_rst_n = 1'b0;
    wait_clk(10);

    xfer(8'hA0, 8'h33, 8'h03, 8'h00, 8'h33, "R2 read before enable echoes");
    xfer(8'hC0, 8'h00, 8'h03, 8'h77, 8'h00, "R2 write before enable");
    xfer(8'hAC, 8'h53, 8'h54, 8'h00, 8'h53, "R3 mismatched enable echo");
    xfer(8'hA0, 8'h44, 8'h03, 8'h00, 8'h44, "R3 still locked after bad enable");
    xfer(8'hAC, 8'h53, 8'h53, 8'h00, 8'h53, "R4 enable echoes byte2");
    xfer(8'hA0, 8'h00, 8'h03, 8'h00, 8'hFF, "R2 R11 locked write left FF");
    xfer(8'h20, 8'h00, 8'h02, 8'h00, 8'hFF, "R11 program reset FF");

    xfer(8'hC0, 8'h00, 8'h03, 8'h5A, 8'h00, "R4 data write echo");
    xfer(8'hF0, 8'h00, 8'h00, 8'h00, 8'h01, "R7 poll busy");
    xfer(8'hC0, 8'h00, 8'h05, 8'h11, 8'h00, "R8 write while busy echo");
    wait_clk(WRC + 100);
    xfer(8'hF0, 8'h00, 8'h00, 8'h00, 8'h00, "R7 poll idle");
    xfer(8'hA0, 8'h00, 8'h03, 8'h00, 8'h5A, "R10 R5 data read");
    xfer(8'hA0, 8'h00, 8'h05, 8'h00, 8'hFF, "R8 busy write dropped");

    xfer(8'hC0, 8'h00, 8'h03, 8'hA5, 8'h00, "R10 overwrite");
    wait_clk(WRC + 100);
    xfer(8'hA0, 8'h00, 8'h03, 8'h00, 8'hA5, "R10 self erase");
    xfer(8'hA0, 8'hF0, 8'h13, 8'h00, 8'hA5, "R12 data address wrap");

    xfer(8'h40, 8'h00, 8'h02, 8'h3C, 8'h00, "R9 program write low");
    wait_clk(WRC + 100);
    xfer(8'h20, 8'h00, 8'h02, 8'h00, 8'h3C, "R9 program low read");
    xfer(8'h28, 8'h00, 8'h02, 8'h00, 8'hFF, "R9 program high untouched");
    xfer(8'h40, 8'h00, 8'h02, 8'hF0, 8'h00, "R9 second write");
    wait_clk(WRC + 100);
    xfer(8'h20, 8'h00, 8'h02, 8'h00, 8'h30, "R9 write ANDs");
    xfer(8'h48, 8'h00, 8'h22, 8'h99, 8'h00, "R12 program high write");
    wait_clk(WRC + 100);
    xfer(8'h28, 8'h00, 8'h02, 8'h00, 8'h99, "R12 program address wrap");

    sck = 1'b1;
    wait_clk(2);
    sck = 1'b0;
    wait_clk(10);
    check("R6 short pulse flagged", 8'(gl_cnt), 8'h01);
    xfer(8'hA0, 8'h00, 8'h03, 8'h00, 8'hA5, "R6 short pulse ignored");

    frame(8'hC0, 8'h00, 8'h07, 8'h6E, 3, r);
    wait_clk(WRC + 100);
    xfer(8'hA0, 8'h00, 8'h07, 8'h00, 8'h6E, "R6 minimum phase accepted");
    check("R6 no flag at minimum phase", 8'(gl_cnt), 8'h01);

    xfer(8'hAC, 8'h80, 8'h00, 8'h00, 8'h80, "R11 erase echo");
    wait_clk(WRC + 100);
    xfer(8'h20, 8'h00, 8'h02, 8'h00, 8'hFF, "R11 program erased");
    xfer(8'hA0, 8'h00, 8'h03, 8'h00, 8'hFF, "R11 data erased");

    for (int i = 0; i < 16; i++) send_bit(1'b1, 10, g);
    tgt_rst_n = 1'b1;
    wait_clk(10);
    check("R1 miso idle while released", {7'b0, miso}, 8'h00);
    tgt_rst_n = 1'b0;
    wait_clk(10);
    xfer(8'hA0, 8'h21, 8'h03, 8'h00, 8'h21, "R1 enable cleared by release");
    xfer(8'hAC, 8'h11, 8'h11, 8'h00, 8'h11, "R1 frame realigned");
    xfer(8'hA0, 8'h00, 8'h07, 8'h00, 8'hFF, "R1 read after re-enable");

    wait_clk(20);
    finish_run();
  end
endmodule